// File: doc/BRIEF.md
# Fronthaul MII Receive Adapter

This block turns a stream of 5-bit code groups, carried by the control-and-management Ethernet channel of a fronthaul link, into a nibble-wide MII-style receive interface for an external Ethernet MAC. A new code group is marked by a per-cycle valid strobe. Because the channel is sparse, a new code group can arrive far less often than once per clock. The block finds the start-of-stream pair (J then K) and the end-of-stream pair (T then R). It decodes data code groups into nibbles and drives a one-cycle write strobe, a data-valid level, an error flag and a 4-bit data bus.

A frame-synchronisation status input from the link gates the whole output. While the link is not synchronised, the MAC sees a fixed error pattern. During reset every output is low. All logic runs on the single core clock, and every output is registered, so each output follows an accepted code group by one clock.

Top module: `fhMiiRxAdapter`

## Requirements
- R1: While `rstN` is low, `miiWr`, `miiDv`, `miiEr` and `miiData` are all 0.
- R2: After reset, while `frameSync` is low, the outputs one clock later are `miiEr`=1, `miiData`=4'b1111, `miiDv`=0 and `miiWr`=0. A loss of `frameSync` inside a packet aborts the packet, and once sync returns the block is idle with all outputs 0.
- R3: An accepted J (11000) followed by an accepted K (10001) opens a packet. One clock after the K is accepted, `miiWr`=1, `miiDv`=1, `miiEr`=0 and `miiData`=4'b0101 (the K nibble). The J alone produces no write.
- R4: Inside a packet, each data code group is decoded by the 4B/5B table (0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101). The nibble appears with `miiWr`=1 for exactly one clock, and `miiDv` and `miiData` then hold until the next accepted code group.
- R5: A code group on `cgData` while `cgValid` is low has no effect on any output.
- R6: An accepted T (01101) followed by an accepted R (00111) closes the packet. T and R produce no write. One clock after R is accepted, `miiDv`, `miiEr`, `miiWr` and `miiData` are all 0.
- R7: Inside a packet, a HALT (00100) or a code group that is neither data nor a control symbol gives `miiWr`=1, `miiDv`=1, `miiEr`=1 and `miiData`=4'b0000. `miiEr` returns to 0 with the next good nibble.
- R8: A J that is not followed by K is discarded and the block returns to idle with all outputs 0. Outside a packet, data code groups and a lone K are ignored.
- R9: After a T, any code group other than R is reported as an error nibble (as in R7), and the block stays inside the packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; also clocks the receive interface |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Link frame-synchronisation status |
| cgValid | input | 1 | Marks a new code group on `cgData` |
| cgData | input | 5 | 4B/5B code group |
| miiWr | output | 1 | One-cycle strobe for a new nibble |
| miiDv | output | 1 | Receive data valid |
| miiEr | output | 1 | Receive error |
| miiData | output | 4 | Receive nibble |

## Verification
The hardest situations to reach are those where two-symbol sequences are cut short. These are a J followed by something other than K, a T followed by something other than R, and a sync loss between the two halves of a packet. In each case the design has to judge the second symbol by an internal state that the ports never show. The directed tasks build each of these sequences explicitly, with idle gaps between the valid strobes. They then check that the data bus and flags keep or drop their value exactly as the requirements state. The same tasks also check that the next well-formed J K still opens a packet cleanly.

// File: rtl/fhMiiPkg.sv
package fhMiiPkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    CG_DATA, CG_J, CG_K, CG_T, CG_R, CG_IDLE, CG_HALT, CG_BAD
  } cgClass_e;

  typedef struct packed {
    cgClass_e          cls;
    logic [NIB_W-1:0]  nib;
  } cgDecode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic emit;   // load a nibble this cycle
    logic err;    // emitted nibble is an error nibble
    logic kNib;   // emitted nibble is the start K
    logic quiet;  // drive all outputs low
  } rxStrobe_t;

  function automatic cgDecode_t decodeCg(input logic [CG_W-1:0] cg);
    cgDecode_t d;
    d.cls = CG_DATA;
    d.nib = '0;
    unique case (cg)
      5'b11110: d.nib = 4'h0;
      5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;
      5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;
      5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;
      5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;
      5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;
      5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;
      5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;
      5'b11101: d.nib = 4'hF;
      5'b11000: d.cls = CG_J;
      5'b10001: d.cls = CG_K;
      5'b01101: d.cls = CG_T;
      5'b00111: d.cls = CG_R;
      5'b11111: d.cls = CG_IDLE;
      5'b00100: d.cls = CG_HALT;
      default:  d.cls = CG_BAD;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/fhMiiRxCtrl.sv
module fhMiiRxCtrl
  import fhMiiPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic       cgValid,
  input  cgClass_e   cgCls,
  output rxStrobe_t  strobe
);
  typedef enum logic [1:0] {S_IDLE, S_GOTJ, S_PKT, S_GOTT} rxState_e;
  rxState_e state, stateNext;

  logic take;
  assign take = cgValid && frameSync;

  always_comb begin
    stateNext    = state;
    strobe       = '0;
    unique case (state)
      S_IDLE: begin
        strobe.quiet = 1'b1;
        if (take && cgCls == CG_J) stateNext = S_GOTJ;
      end
      S_GOTJ: begin
        if (take) begin
          if (cgCls == CG_K) begin
            stateNext   = S_PKT;
            strobe.emit = 1'b1;
            strobe.kNib = 1'b1;
          end else begin
            stateNext    = S_IDLE;
            strobe.quiet = 1'b1;
          end
        end else begin
          strobe.quiet = 1'b1;
        end
      end
      S_PKT: begin
        if (take) begin
          if (cgCls == CG_T) begin
            stateNext = S_GOTT;
          end else begin
            strobe.emit = 1'b1;
            strobe.err  = (cgCls != CG_DATA);
          end
        end
      end
      S_GOTT: begin
        if (take) begin
          if (cgCls == CG_R) begin
            stateNext    = S_IDLE;
            strobe.quiet = 1'b1;
          end else begin
            stateNext   = S_PKT;
            strobe.emit = 1'b1;
            strobe.err  = 1'b1;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           state <= S_IDLE;
    else if (!frameSync) state <= S_IDLE;
    else                 state <= stateNext;
  end

  // R3: a K nibble is only produced as the first write of a packet
  a_r3_k_from_gotj: assert property (@(posedge clk) disable iff (!rstN)
    strobe.kNib |-> (state == S_GOTJ && strobe.emit));

  // R8: outside a packet nothing but a start K is ever emitted
  a_r8_idle_no_emit: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !strobe.emit);
endmodule

// File: rtl/fhMiiRxDatapath.sv
module fhMiiRxDatapath
  import fhMiiPkg::*;
#(
  parameter logic [NIB_W-1:0] K_NIBBLE = 4'b0101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic [CG_W-1:0]   cgData,
  input  rxStrobe_t         strobe,
  output cgClass_e          cgCls,
  output logic              miiWr,
  output logic              miiDv,
  output logic              miiEr,
  output logic [NIB_W-1:0]  miiData
);
  cgDecode_t dec;
  assign dec   = decodeCg(cgData);
  assign cgCls = dec.cls;

  logic [NIB_W-1:0] nibNext;
  always_comb begin
    if (strobe.err)       nibNext = '0;
    else if (strobe.kNib) nibNext = K_NIBBLE;
    else                  nibNext = dec.nib;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      miiWr   <= 1'b0;
      miiDv   <= 1'b0;
      miiEr   <= 1'b0;
      miiData <= '0;
    end else if (!frameSync) begin
      miiWr   <= 1'b0;
      miiDv   <= 1'b0;
      miiEr   <= 1'b1;
      miiData <= '1;
    end else if (strobe.emit) begin
      miiWr   <= 1'b1;
      miiDv   <= 1'b1;
      miiEr   <= strobe.err;
      miiData <= nibNext;
    end else if (strobe.quiet) begin
      miiWr   <= 1'b0;
      miiDv   <= 1'b0;
      miiEr   <= 1'b0;
      miiData <= '0;
    end else begin
      miiWr   <= 1'b0;
    end
  end

  // R2: no sync forces the fixed error pattern on the next clock
  a_r2_nosync_pattern: assert property (@(posedge clk) disable iff (!rstN)
    !frameSync |=> (miiEr && miiData == '1 && !miiDv && !miiWr));

  // R7: an error inside a packet carries the zero nibble
  a_r7_err_nibble: assert property (@(posedge clk) disable iff (!rstN)
    (miiEr && miiDv) |-> (miiData == '0));
endmodule

// File: rtl/fhMiiRxAdapter.sv
module fhMiiRxAdapter
  import fhMiiPkg::*;
#(
  parameter logic [3:0] K_NIBBLE = 4'b0101
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic       cgValid,
  input  logic [4:0] cgData,
  output logic       miiWr,
  output logic       miiDv,
  output logic       miiEr,
  output logic [3:0] miiData
);
  rxStrobe_t strobe;
  cgClass_e  cgCls;

  fhMiiRxCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .cgValid   (cgValid),
    .cgCls     (cgCls),
    .strobe    (strobe)
  );

  fhMiiRxDatapath #(.K_NIBBLE(K_NIBBLE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .cgData    (cgData),
    .strobe    (strobe),
    .cgCls     (cgCls),
    .miiWr     (miiWr),
    .miiDv     (miiDv),
    .miiEr     (miiEr),
    .miiData   (miiData)
  );

  // R4: a write strobe only appears with data valid
  a_r4_wr_in_packet: assert property (@(posedge clk) disable iff (!rstN)
    miiWr |-> miiDv);

  // R5: a write strobe needs an accepted code group one clock earlier
  a_r5_wr_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    miiWr |-> $past(cgValid));
endmodule

// File: tb/fhMiiRxAdapter_tb.sv
module fhMiiRxAdapter_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameSync = 1'b0;
  logic       cgValid = 1'b0;
  logic [4:0] cgData = 5'b11111;
  logic       miiWr, miiDv, miiEr;
  logic [3:0] miiData;

  int nChecks = 0;
  int nFails  = 0;

  localparam logic [4:0] CJ = 5'b11000, CK = 5'b10001, CT = 5'b01101,
                         CR = 5'b00111, CI = 5'b11111, CH = 5'b00100,
                         CBAD = 5'b00000;

  always #2 clk = ~clk;  // 250 MHz

  fhMiiRxAdapter u_dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .cgValid(cgValid),
    .cgData(cgData), .miiWr(miiWr), .miiDv(miiDv), .miiEr(miiEr),
    .miiData(miiData)
  );

  function automatic logic [4:0] enc(input int n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic logic [6:0] pk(input logic w, input logic d,
                                    input logic e, input logic [3:0] n);
    return {w, d, e, n};
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    logic [6:0] act;
    act = {miiWr, miiDv, miiEr, miiData};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: act wr/dv/er/data=%b expected %b", tag, act, exp);
    end
  endtask

  // one accepted code group; returns at the negedge where outputs reflect it
  task automatic sendCg(input logic [4:0] c);
    @(negedge clk);
    cgValid = 1'b1;
    cgData  = c;
    @(negedge clk);
    cgValid = 1'b0;
    cgData  = CI;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    gap(2);
    check("R1 reset outputs low", pk(0, 0, 0, 4'h0));
    @(negedge clk) rstN = 1'b1;
    gap(2);
    check("R2 nosync pattern", pk(0, 0, 1, 4'hF));
    sendCg(CJ);
    sendCg(CK);
    check("R2 no packet without sync", pk(0, 0, 1, 4'hF));
  endtask

  task automatic testOpen();
    frameSync = 1'b1;
    gap(2);
    check("R2 sync reached idle low", pk(0, 0, 0, 4'h0));
    sendCg(CJ);
    check("R3 J alone no write", pk(0, 0, 0, 4'h0));
    sendCg(CK);
    check("R3 K nibble written", pk(1, 1, 0, 4'h5));
    gap(1);
    check("R4 strobe one cycle, hold", pk(0, 1, 0, 4'h5));
  endtask

  task automatic testData();
    for (int i = 0; i < 16; i++) begin
      sendCg(enc(i));
      check($sformatf("R4 data nibble %0d", i), pk(1, 1, 0, 4'(i)));
      gap(i % 3);
      if (i % 3 != 0) check("R4 hold in gap", pk(0, 1, 0, 4'(i)));
    end
    cgData = enc(3);
    gap(3);
    check("R5 no valid ignored", pk(0, 1, 0, 4'hF));
    cgData = CI;
  endtask

  task automatic testErrors();
    sendCg(CH);
    check("R7 halt error nibble", pk(1, 1, 1, 4'h0));
    sendCg(enc(3));
    check("R7 error clears", pk(1, 1, 0, 4'h3));
    sendCg(CBAD);
    check("R7 invalid code error", pk(1, 1, 1, 4'h0));
    sendCg(enc(10));
    check("R7 recover A", pk(1, 1, 0, 4'hA));
  endtask

  task automatic testBadEnd();
    sendCg(CT);
    check("R6 T no write", pk(0, 1, 0, 4'hA));
    sendCg(enc(7));
    check("R9 T then data error", pk(1, 1, 1, 4'h0));
    sendCg(enc(2));
    check("R9 still in packet", pk(1, 1, 0, 4'h2));
  endtask

  task automatic testClose();
    sendCg(CT);
    check("R6 T holds", pk(0, 1, 0, 4'h2));
    gap(2);
    sendCg(CR);
    check("R6 dv drops after R", pk(0, 0, 0, 4'h0));
    sendCg(enc(6));
    check("R8 data in idle ignored", pk(0, 0, 0, 4'h0));
  endtask

  task automatic testDiscardJ();
    sendCg(CJ);
    sendCg(enc(0));
    check("R8 J then data discarded", pk(0, 0, 0, 4'h0));
    sendCg(CK);
    check("R8 lone K ignored", pk(0, 0, 0, 4'h0));
    sendCg(CJ);
    sendCg(CK);
    check("R3 reopen after discard", pk(1, 1, 0, 4'h5));
  endtask

  task automatic testSyncLoss();
    sendCg(enc(9));
    check("R4 nibble 9", pk(1, 1, 0, 4'h9));
    @(negedge clk) frameSync = 1'b0;
    @(negedge clk);
    check("R2 sync loss aborts", pk(0, 0, 1, 4'hF));
    frameSync = 1'b1;
    @(negedge clk);
    check("R2 resync idle", pk(0, 0, 0, 4'h0));
    sendCg(enc(1));
    check("R2 no packet after resync", pk(0, 0, 0, 4'h0));
  endtask

  initial begin
    testReset();
    testOpen();
    testData();
    testErrors();
    testBadEnd();
    testClose();
    testDiscardJ();
    testSyncLoss();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: act running expected done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule